// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block paces full-speed USB frames for a host controller. Software writes one 32-bit control word. The word holds the frame length in bit times, a per-frame budget for the largest data packet, and a flag that software flips each time it changes the frame length. A 12 MHz bit-time strobe drives a countdown of the bit times left in the current frame. When the countdown has reached zero and a strobe arrives, the block emits a one-clock start-of-frame pulse and begins the next frame. At that boundary it reloads the countdown from the frame length, reloads the packet budget counter from the budget field and advances a 16-bit frame number.

A host-controller-reset command puts the frame length back to its nominal 11999. Software can then restore a value it saved before the reset. The scheduler outside this block reads the bit times left and the packet budget to decide whether a transaction still fits in the current frame.

Top module: `usb_frame_timer`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0x00002EDF (flag 0, budget 0, frame length 11999), `bits_left` is 11999, `pkt_budget` is 0, `frame_num` is 0 and `sof` is 0.
- R2: A write with `wr_en` stores bits 13:0 as the frame length, bits 30:16 as the packet budget and bit 31 as the toggle flag. `rd_data` returns these fields at the same positions from the next cycle. The flag is only stored.
- R3: Bits 15:14 of `rd_data` always read 0, whatever is written to them.
- R4: `bits_left` falls by exactly one on each clock edge where `bit_tick` is high and it is nonzero. It does not change on edges without `bit_tick`.
- R5: On an edge where `bit_tick` is high and `bits_left` is 0, `bits_left` reloads with the stored frame length and `sof` is high for the following cycle. Frames are therefore frame length + 1 strobes apart, and the first `sof` after reset follows the 12000th strobe.
- R6: A new frame length written during a frame does not change the frame in progress. It first sets the length of the frame after the next `sof`.
- R7: `pkt_budget` loads the stored budget field together with each `sof`. After that it falls by one per strobe and holds at 0.
- R8: `frame_num` rises by one in the same cycle as each `sof` and wraps from 65535 to 0. It does not change at other times.
- R9: When `hc_reset` is high on an edge, the frame length becomes 11999. This takes priority over a simultaneous write, which still updates the flag and the budget. The counters are not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| hc_reset | input | 1 | Host-controller-reset command, restores nominal frame length |
| bit_tick | input | 1 | One-clock enable per full-speed bit time |
| sof | output | 1 | One-clock start-of-frame pulse |
| bits_left | output | 14 | Bit times remaining in the current frame |
| pkt_budget | output | 15 | Largest-data-packet budget remaining in this frame |
| frame_num | output | 16 | Frame number |

## Verification
The first pattern applies back-to-back strobes with the nominal length. This separates an off-by-one reload (period of length versus length + 1) from a correct one. A length written mid-frame then shows whether the change leaks into the running frame. Strobes spaced three clocks apart show that the counters move on strobes and not on clocks, and that saturation holds the budget at zero across idle cycles. A frame length of zero gives a start-of-frame on every strobe, which walks the frame number through its full wrap. A reset command issued together with a write tells apart which fields the reset overrides.

// File: rtl/fit_pkg.sv
package fit_pkg;
  localparam int REG_W      = 32;
  localparam int IV_W       = 14;
  localparam int IV_LSB     = 0;
  localparam int LDP_W      = 15;
  localparam int LDP_LSB    = 16;
  localparam int TGL_BIT    = 31;
  localparam int FN_W       = 16;
  localparam int NOMINAL_IV = 11999;

  typedef struct packed {
    logic             tgl;
    logic [LDP_W-1:0] ldp;
    logic [IV_W-1:0]  iv;
  } fit_ctrl_t;

  // Place the fields at their register positions; everything else reads 0.
  function automatic logic [REG_W-1:0] ctrl_to_word(fit_ctrl_t c);
    logic [REG_W-1:0] w;
    w                   = '0;
    w[TGL_BIT]          = c.tgl;
    w[LDP_LSB +: LDP_W] = c.ldp;
    w[IV_LSB +: IV_W]   = c.iv;
    return w;
  endfunction

  function automatic fit_ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
    fit_ctrl_t c;
    c.tgl = w[TGL_BIT];
    c.ldp = w[LDP_LSB +: LDP_W];
    c.iv  = w[IV_LSB +: IV_W];
    return c;
  endfunction

  // Next frame countdown value on a strobe.
  function automatic logic [IV_W-1:0] next_left(logic [IV_W-1:0] left,
                                                logic [IV_W-1:0] iv);
    return (left == '0) ? iv : left - 1'b1;
  endfunction

  // Saturating decrement of the packet budget.
  function automatic logic [LDP_W-1:0] budget_dec(logic [LDP_W-1:0] b);
    return (b == '0) ? b : b - 1'b1;
  endfunction
endpackage

// File: rtl/fit_ctrl_reg.sv
module fit_ctrl_reg
  import fit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hc_reset,
  output fit_ctrl_t        ctrl
);
  localparam logic [IV_W-1:0] NOM = IV_W'(NOMINAL_IV);

  fit_ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt = ctrl;
    if (wr_en)    ctrl_nxt = word_to_ctrl(wr_data);
    if (hc_reset) ctrl_nxt.iv = NOM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.tgl <= 1'b0;
      ctrl.ldp <= '0;
      ctrl.iv  <= NOM;
    end else begin
      ctrl <= ctrl_nxt;
    end
  end
endmodule

// File: rtl/fit_period_ctr.sv
module fit_period_ctr
  import fit_pkg::*;
#(
  parameter int W        = IV_W,
  parameter int RESET_IV = NOMINAL_IV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] reload_iv,
  output logic [W-1:0] left,
  output logic         frame_end,
  output logic         sof_q
);
  assign frame_end = tick && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= W'(RESET_IV);
      sof_q <= 1'b0;
    end else begin
      sof_q <= frame_end;
      if (tick) left <= next_left(left, reload_iv);
    end
  end
endmodule

// File: rtl/fit_budget_ctr.sv
module fit_budget_ctr
  import fit_pkg::*;
#(
  parameter int W = LDP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] budget
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    budget <= '0;
    else if (load) budget <= load_val;
    else if (tick) budget <= budget_dec(budget);
  end
endmodule

// File: rtl/fit_frame_cnt.sv
module fit_frame_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import fit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             hc_reset,
  input  logic             bit_tick,
  output logic             sof,
  output logic [IV_W-1:0]  bits_left,
  output logic [LDP_W-1:0] pkt_budget,
  output logic [FN_W-1:0]  frame_num
);
  fit_ctrl_t ctrl;
  logic      frame_end;   // strobe arriving with the countdown at zero

  fit_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .hc_reset (hc_reset),
    .ctrl     (ctrl)
  );

  fit_period_ctr #(.W(IV_W), .RESET_IV(NOMINAL_IV)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .reload_iv (ctrl.iv),
    .left      (bits_left),
    .frame_end (frame_end),
    .sof_q     (sof)
  );

  fit_budget_ctr #(.W(LDP_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .load     (frame_end),
    .load_val (ctrl.ldp),
    .budget   (pkt_budget)
  );

  fit_frame_cnt #(.W(FN_W)) u_fnum (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (frame_end),
    .count (frame_num)
  );

  assign rd_data = ctrl_to_word(ctrl);
endmodule

// File: rtl/fit_checker.sv
module fit_checker
  import fit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             hc_reset,
  input logic             bit_tick,
  input logic             frame_end,
  input logic             sof,
  input logic [IV_W-1:0]  bits_left,
  input logic [LDP_W-1:0] pkt_budget,
  input logic [FN_W-1:0]  frame_num,
  input logic [REG_W-1:0] rd_data
);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[IV_LSB+IV_W +: 2] == 2'b00);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(bits_left));

  a_r5_sof_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> sof);

  a_r5_sof_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> $past(frame_end));

  a_r7_budget_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> pkt_budget <= $past(pkt_budget));

  a_r8_fnum_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> frame_num == FN_W'($past(frame_num) + 1'b1));

  a_r8_fnum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame_num));

  a_r9_nominal_restore: assert property (@(posedge clk) disable iff (!rst_n)
    hc_reset |=> rd_data[IV_LSB +: IV_W] == IV_W'(NOMINAL_IV));
endmodule

bind usb_frame_timer fit_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hc_reset   (hc_reset),
  .bit_tick   (bit_tick),
  .frame_end  (frame_end),
  .sof        (sof),
  .bits_left  (bits_left),
  .pkt_budget (pkt_budget),
  .frame_num  (frame_num),
  .rd_data    (rd_data)
);

// File: tb/usb_frame_timer_test.sv
`timescale 1ns/1ps
module usb_frame_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        hc_reset = 1'b0;
  logic        bit_tick = 1'b0;
  logic        sof;
  logic [13:0] bits_left;
  logic [14:0] pkt_budget;
  logic [15:0] frame_num;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Model of the stored register fields (from R2, R9).
  int m_iv = 11999, m_ldp = 0, m_tgl = 0;
  // Values in force for the running frame (from R5, R6, R7).
  int a_iv = 11999, a_ldp = 0;
  int cnt = 0;            // strobes processed since the last SOF
  int exp_fn = 0;
  bit mon_on = 1'b0;
  int gap_q[$];           // expected strobe counts between SOFs

  always #2.5 clk = ~clk;

  usb_frame_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hc_reset(hc_reset), .bit_tick(bit_tick),
    .sof(sof), .bits_left(bits_left), .pkt_budget(pkt_budget),
    .frame_num(frame_num)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: strobes, each followed by space-1 idle cycles.
  task automatic ticks(int n, int space);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(posedge clk); #1;
      bit_tick = 1'b0;
      for (int j = 1; j < space; j++) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic push_gaps(int gap, int n);
    for (int i = 0; i < n; i++) gap_q.push_back(gap);
  endtask

  task automatic reg_write(logic [31:0] d, bit hcr);
    wr_en = 1'b1; wr_data = d; hc_reset = hcr;
    @(posedge clk); #1;
    wr_en = 1'b0; hc_reset = 1'b0;
    m_tgl = d[31]; m_ldp = d[30:16]; m_iv = d[13:0];
    if (hcr) m_iv = 11999;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      if (sof) begin
        if (gap_q.size() == 0) begin
          check(1'b0, "R5", "unexpected SOF after strobes", cnt, -1);
        end else begin
          int g;
          g = gap_q.pop_front();
          check(cnt == g, "R5/R6", "strobes between SOFs", cnt, g);
        end
        exp_fn = (exp_fn + 1) % 65536;
        check(frame_num == exp_fn, "R8", "frame number at SOF", frame_num, exp_fn);
        a_iv = m_iv; a_ldp = m_ldp; cnt = 0;
      end
      check(bits_left == a_iv - cnt, "R4", "bits left", bits_left, a_iv - cnt);
      check(pkt_budget == ((a_ldp > cnt) ? a_ldp - cnt : 0), "R7", "packet budget",
            pkt_budget, (a_ldp > cnt) ? a_ldp - cnt : 0);
      if (bit_tick) cnt++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int fn_before;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rd_data == 32'h0000_2EDF, "R1", "register after reset", rd_data, 32'h0000_2EDF);
    check(bits_left == 11999, "R1", "bits left after reset", bits_left, 11999);
    check(pkt_budget == 0, "R1", "budget after reset", pkt_budget, 0);
    check(frame_num == 0, "R1", "frame number after reset", frame_num, 0);
    check(sof == 1'b0, "R1", "sof after reset", sof, 0);
    @(posedge clk); #1;
    mon_on = 1'b1;

    // R5: first SOF on the 12000th back-to-back strobe
    push_gaps(12000, 1);
    ticks(12000, 1);

    // R2, R3: write fields, reserved bits set but read as 0
    reg_write(32'h8005_C009, 1'b0);
    @(negedge clk);
    check(rd_data == 32'h8005_0009, "R2/R3", "readback with reserved bits", rd_data, 32'h8005_0009);
    check(rd_data[15:14] == 2'b00, "R3", "reserved bits", rd_data[15:14], 0);
    @(posedge clk); #1;

    // R6: frame in progress keeps 11999, then period 10
    push_gaps(12000, 1);
    push_gaps(10, 2);
    ticks(12020, 1);

    // R4, R7: strobes spaced three clocks, budget saturates between
    push_gaps(10, 2);
    ticks(20, 3);

    // R8: frame length 0 gives SOF per strobe; walk the full wrap
    reg_write(32'h0005_0000, 1'b0);
    push_gaps(10, 1);
    ticks(10, 1);
    fn_before = frame_num;
    push_gaps(1, 65536);
    ticks(65536, 1);
    @(negedge clk);
    check(frame_num == fn_before, "R8", "frame number after full wrap", frame_num, fn_before);
    @(posedge clk); #1;

    // R9: reset command wins over the write for the frame length only
    reg_write(32'h8003_0005, 1'b1);
    @(negedge clk);
    check(rd_data == 32'h8003_2EDF, "R9", "register after reset command", rd_data, 32'h8003_2EDF);
    check(bits_left == 0, "R9", "countdown undisturbed", bits_left, 0);
    @(posedge clk); #1;
    push_gaps(1, 1);
    push_gaps(12000, 1);
    ticks(12001, 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(gap_q.size() == 0, "R5", "expected SOFs outstanding", gap_q.size(), 0);
    mon_on = 1'b0;
    finish_run();
  end
endmodule